// File: doc/BRIEF.md
# Timer Output-Compare Channel with Software Force

This block is a single output-compare channel for a 16-bit timer. Each clock it compares the running count against a compare value. When the two are equal on a cycle where the timer advances, a compare event occurs. The event drives the waveform pin according to a 2-bit action code and sets a sticky match flag. If the timer runs in clear-on-compare mode with this channel as its top value, the event also raises a one-cycle clear request back to the counter.

Software can also cause a compare event through a one-cycle force strobe. A forced event acts on the pin exactly as a real match would. It uses the action code present in the cycle of the strobe. It never sets the match flag and never requests a timer clear. The strobe only works while the timer is in a non-PWM waveform mode; in any PWM mode it is ignored. The strobe is not stored, so there is nothing in the block to read back.

All three outputs are registered. Each responds one clock after the inputs that caused it.

Top module: `ocu_channel`

## Requirements
- R1: While rst_n is low at a rising clock edge, wave_o, match_flag_o and clear_req_o are all 0 after that edge.
- R2: A genuine match means count_i equals compare_i while count_en_i is 1. It sets match_flag_o one cycle later. Equal values while count_en_i is 0 cause no event.
- R3: With action code 2'b00 (disconnected), a compare event leaves wave_o at its previous value.
- R4: On a compare event, action code 2'b01 inverts wave_o, 2'b10 drives it to 0 and 2'b11 drives it to 1. The new level appears one cycle after the event.
- R5: A force strobe (force_i = 1) while non_pwm_i = 1 changes wave_o in the same way as a genuine match.
- R6: A force strobe while non_pwm_i = 0 has no effect on wave_o.
- R7: A force strobe does not set match_flag_o.
- R8: A force strobe does not assert clear_req_o, even while ctc_top_i = 1.
- R9: A genuine match while ctc_top_i = 1 drives clear_req_o high for exactly the following cycle. With ctc_top_i = 0, clear_req_o stays 0.
- R10: A genuine match and a force strobe in the same cycle update wave_o only once, so a toggle inverts it a single time. match_flag_o is still set.
- R11: match_flag_o stays set until flag_clr_i is 1 at a clock edge. If a genuine match coincides with flag_clr_i, the flag stays set.
- R12: For a forced event, the action code in the cycle of the strobe decides the result. The codes before and after that cycle play no part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 16 | Running timer count |
| compare_i | input | 16 | Compare value |
| count_en_i | input | 1 | Timer advances this cycle |
| com_mode_i | input | 2 | Pin action: 00 none, 01 toggle, 10 clear, 11 set |
| non_pwm_i | input | 1 | Timer is in a non-PWM waveform mode |
| ctc_top_i | input | 1 | Clear-on-compare mode with this channel as top |
| force_i | input | 1 | One-cycle software force strobe |
| flag_clr_i | input | 1 | Clears the match flag |
| wave_o | output | 1 | Waveform pin |
| match_flag_o | output | 1 | Sticky compare-match interrupt flag |
| clear_req_o | output | 1 | One-cycle timer clear request |

## Verification
The bench targets the cases where a forced event and a genuine match must differ. It checks that a force in clear-on-compare mode raises neither the flag nor the clear request; a design that reused the match path for forces would fire the interrupt or reset the counter. It applies a toggle with a match and a force in the same cycle; a design that OR-ed two separate updates, or applied one after the other, would toggle twice or lose the flag. It also changes the action code on the cycles around a strobe and forces while in a PWM mode, which catches designs that latch the code late or ignore the mode qualifier. Equal counts with count_en_i low and a flag clear that coincides with a match are covered as well.

// File: rtl/ocu_pkg.sv
// Package: shared types for the output-compare channel.
// Assumes the action code is 2 bits wide.
package ocu_pkg;
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } pin_act_e;
endpackage

// File: rtl/ocu_event.sv
// Module: ocu_event
// Builds the event qualifiers for one channel: a genuine match (equal
// values while the timer advances) and a qualified force (strobe while in a
// non-PWM mode). Purely combinational; it assumes the inputs are synchronous.
module ocu_event #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic             count_en_i,
    input  logic             non_pwm_i,
    input  logic             force_i,
    output logic             match_ev_o,
    output logic             force_ev_o,
    output logic             pin_ev_o
);
    // Qualify the comparator and the strobe, then merge them for the pin path.
    always_comb begin
        match_ev_o = count_en_i && (count_i == compare_i);
        force_ev_o = force_i && non_pwm_i;
        pin_ev_o   = match_ev_o || force_ev_o;
    end
endmodule

// File: rtl/ocu_wave.sv
// Module: ocu_wave
// Holds the waveform pin register. It applies the action code once per
// event, so a merged match and force update the pin a single time. It assumes
// pin_ev_i is already qualified.
module ocu_wave
    import ocu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_ev_i,
    input  pin_act_e act_i,
    output logic     wave_o
);
    logic wave_q;
    logic wave_d;

    // Choose the next pin level from the action code.
    always_comb begin
        wave_d = wave_q;
        if (pin_ev_i) begin
            case (act_i)
                ACT_NONE:   wave_d = wave_q;
                ACT_TOGGLE: wave_d = ~wave_q;
                ACT_CLEAR:  wave_d = 1'b0;
                ACT_SET:    wave_d = 1'b1;
                default:    wave_d = wave_q;
            endcase
        end
    end

    // Register the pin; reset drives it low.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    assign wave_o = wave_q;

    assert_none_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ev_i && act_i == ACT_NONE) |=> $stable(wave_o));
    assert_toggle_inverts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ev_i && act_i == ACT_TOGGLE) |=> (wave_o != $past(wave_o)));
    assert_set_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ev_i && act_i == ACT_SET) |=> wave_o);
    assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ev_i && act_i == ACT_CLEAR) |=> !wave_o);
endmodule

// File: rtl/ocu_flag.sv
// Module: ocu_flag
// Holds the sticky match flag and the one-cycle clear request. Only genuine
// matches reach this module, so a force can touch neither output.
module ocu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_ev_i,
    input  logic ctc_top_i,
    input  logic flag_clr_i,
    output logic match_flag_o,
    output logic clear_req_o
);
    logic flag_q;
    logic clr_req_q;

    // Set the flag on a match; a clear only takes effect without a match.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (match_ev_i) flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    // Pulse the clear request on a match in clear-on-compare mode.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_req_q <= 1'b0;
        else        clr_req_q <= match_ev_i && ctc_top_i;
    end

    assign match_flag_o = flag_q;
    assign clear_req_o  = clr_req_q;

    assert_match_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_ev_i |=> match_flag_o);
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag_o && !flag_clr_i) |=> match_flag_o);
    assert_no_req_without_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !match_ev_i |=> !clear_req_o);
endmodule

// File: rtl/ocu_channel.sv
// Module: ocu_channel (top)
// One output-compare channel: it detects events, drives the waveform pin and
// keeps the interrupt flag and the timer clear request. It assumes a
// synchronous active-low reset and inputs that are stable around the clock edge.
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic             count_en_i,
    input  logic [1:0]       com_mode_i,
    input  logic             non_pwm_i,
    input  logic             ctc_top_i,
    input  logic             force_i,
    input  logic             flag_clr_i,
    output logic             wave_o,
    output logic             match_flag_o,
    output logic             clear_req_o
);
    logic     match_ev;
    logic     force_ev;
    logic     pin_ev;
    pin_act_e act;

    // Map the raw action code onto the shared enum.
    always_comb act = pin_act_e'(com_mode_i);

    ocu_event #(.CNT_W(CNT_W)) u_event (
        .count_i    (count_i),
        .compare_i  (compare_i),
        .count_en_i (count_en_i),
        .non_pwm_i  (non_pwm_i),
        .force_i    (force_i),
        .match_ev_o (match_ev),
        .force_ev_o (force_ev),
        .pin_ev_o   (pin_ev)
    );

    ocu_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_ev_i (pin_ev),
        .act_i    (act),
        .wave_o   (wave_o)
    );

    ocu_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .match_ev_i   (match_ev),
        .ctc_top_i    (ctc_top_i),
        .flag_clr_i   (flag_clr_i),
        .match_flag_o (match_flag_o),
        .clear_req_o  (clear_req_o)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!wave_o && !match_flag_o && !clear_req_o));
    assert_pwm_force_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !non_pwm_i && !(count_en_i && count_i == compare_i)) |=> $stable(wave_o));
    assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ev && !match_ev && !match_flag_o) |=> !match_flag_o);
    assert_force_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ev && !match_ev) |=> !clear_req_o);
endmodule

// File: tb/ocu_channel_tb.sv
module ocu_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] count_i;
    logic [CNT_W-1:0] compare_i;
    logic             count_en_i;
    logic [1:0]       com_mode_i;
    logic             non_pwm_i;
    logic             ctc_top_i;
    logic             force_i;
    logic             flag_clr_i;
    logic             wave_o;
    logic             match_flag_o;
    logic             clear_req_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocu_channel #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .compare_i(compare_i),
        .count_en_i(count_en_i), .com_mode_i(com_mode_i), .non_pwm_i(non_pwm_i),
        .ctc_top_i(ctc_top_i), .force_i(force_i), .flag_clr_i(flag_clr_i),
        .wave_o(wave_o), .match_flag_o(match_flag_o), .clear_req_o(clear_req_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Advance one edge, then sample 1 time unit after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Return strobes to quiet values; count differs from compare.
    task automatic idle();
        count_i    = 16'd7;
        compare_i  = 16'd300;
        count_en_i = 1'b1;
        force_i    = 1'b0;
        flag_clr_i = 1'b0;
    endtask

    // Apply one cycle: genuine match (mt), force (fc), with the given code.
    task automatic apply(input logic mt, input logic fc, input logic [1:0] code);
        count_i    = 16'd300;
        compare_i  = mt ? 16'd300 : 16'd301;
        com_mode_i = code;
        force_i    = fc;
        tick();
        idle();
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle();
        com_mode_i = 2'b11; non_pwm_i = 1'b1; ctc_top_i = 1'b1;
        count_i = 16'd300; compare_i = 16'd300;
        tick(); tick();
        chk("R1", "wave after reset", wave_o, 1'b0);
        chk("R1", "flag after reset", match_flag_o, 1'b0);
        chk("R1", "clear req after reset", clear_req_o, 1'b0);
        idle();
        rst_n = 1'b1;
        ctc_top_i = 1'b0;
        tick();
    endtask

    task automatic t_match_codes();
        apply(1'b1, 1'b0, 2'b11);
        chk("R4", "set code drives 1", wave_o, 1'b1);
        chk("R2", "match sets flag", match_flag_o, 1'b1);
        apply(1'b1, 1'b0, 2'b00);
        chk("R3", "none code holds 1", wave_o, 1'b1);
        apply(1'b1, 1'b0, 2'b01);
        chk("R4", "toggle 1->0", wave_o, 1'b0);
        apply(1'b1, 1'b0, 2'b00);
        chk("R3", "none code holds 0", wave_o, 1'b0);
        apply(1'b1, 1'b0, 2'b01);
        chk("R4", "toggle 0->1", wave_o, 1'b1);
        apply(1'b1, 1'b0, 2'b10);
        chk("R4", "clear code drives 0", wave_o, 1'b0);
        clear_flag();
        chk("R11", "flag cleared", match_flag_o, 1'b0);
    endtask

    task automatic t_enable_gate();
        count_en_i = 1'b0;
        count_i = 16'd300; compare_i = 16'd300; com_mode_i = 2'b11;
        tick();
        chk("R2", "disabled equal: wave", wave_o, 1'b0);
        chk("R2", "disabled equal: flag", match_flag_o, 1'b0);
        idle();
    endtask

    task automatic t_force();
        non_pwm_i = 1'b1; ctc_top_i = 1'b1;
        apply(1'b0, 1'b1, 2'b11);
        chk("R5", "force set code", wave_o, 1'b1);
        chk("R7", "force leaves flag", match_flag_o, 1'b0);
        chk("R8", "force no clear req", clear_req_o, 1'b0);
        apply(1'b0, 1'b1, 2'b01);
        chk("R5", "force toggle", wave_o, 1'b0);
        chk("R8", "force toggle no clear req", clear_req_o, 1'b0);
        non_pwm_i = 1'b0;
        apply(1'b0, 1'b1, 2'b11);
        chk("R6", "PWM force ignored (set)", wave_o, 1'b0);
        apply(1'b0, 1'b1, 2'b01);
        chk("R6", "PWM force ignored (toggle)", wave_o, 1'b0);
        chk("R7", "PWM force leaves flag", match_flag_o, 1'b0);
        non_pwm_i = 1'b1; ctc_top_i = 1'b0;
    endtask

    task automatic t_code_timing();
        // Code is 11 before and after, 10 only in the strobe cycle.
        apply(1'b0, 1'b1, 2'b11);
        chk("R12", "pre-set to 1", wave_o, 1'b1);
        com_mode_i = 2'b11; tick();
        apply(1'b0, 1'b1, 2'b10);
        com_mode_i = 2'b11;
        chk("R12", "strobe-cycle code used", wave_o, 1'b0);
        tick();
        chk("R12", "later code unused", wave_o, 1'b0);
    endtask

    task automatic t_ctc();
        ctc_top_i = 1'b1;
        apply(1'b1, 1'b0, 2'b00);
        chk("R9", "clear req pulses", clear_req_o, 1'b1);
        tick();
        chk("R9", "clear req one cycle", clear_req_o, 1'b0);
        ctc_top_i = 1'b0;
        apply(1'b1, 1'b0, 2'b00);
        chk("R9", "no req outside CTC", clear_req_o, 1'b0);
        clear_flag();
    endtask

    task automatic t_coincide();
        apply(1'b1, 1'b1, 2'b01);
        chk("R10", "single toggle 0->1", wave_o, 1'b1);
        chk("R10", "flag set on coincidence", match_flag_o, 1'b1);
        tick();
        chk("R11", "flag holds", match_flag_o, 1'b1);
        clear_flag();
        flag_clr_i = 1'b1;
        apply(1'b1, 1'b0, 2'b00);
        chk("R11", "match beats clear", match_flag_o, 1'b1);
        clear_flag();
    endtask

    initial begin
        t_reset();
        t_match_codes();
        t_enable_gate();
        t_force();
        t_code_timing();
        t_ctc();
        t_coincide();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule